// File: doc/BRIEF.md
# Interrupt Controller Processor-Side Interface

This block is the per-core end of an interrupt controller. A distributor upstream presents its single best candidate for the core as a valid flag, a 10-bit interrupt number, a 3-bit originating-core number and an 8-bit priority. In priority values, a smaller number means a more urgent interrupt. The block turns that candidate into one request line to the core. It gates the request with an enable bit and a priority threshold. While a handler runs, it also requires the newcomer to out-rank the running handler at group granularity.

Software works through a small word-addressed register bus. Reading the acknowledge register claims the presented interrupt. The claim returns its identity and pushes the interrupt onto an internal stack of active handlers, so handlers can nest. Writing the matching identity to the end-of-interrupt register retires the newest handler. The running-priority register always shows the priority of the innermost active handler. The grouping width for pre-emption comes from a binary-point register with a configurable floor.

Top module: `intc_cpu_if`

## Requirements
- R1: After reset the control register reads 0, the threshold register reads 0, the binary-point register reads BP_MIN (default 3), running priority reads 0xFF and the request line is low.
- R2: The request line is high one cycle after the enable bit (control bit 0) is set, the candidate is valid and its priority is strictly numerically smaller than the threshold. The threshold is kept in bits 7:4 of the register at offset 0x04 and compared as {threshold,4'h0}. A write to bits 3:0 of that register has no effect.
- R3: With the enable bit clear, the request line stays low and a read of the acknowledge register (offset 0x0C) returns 0x3FF without changing the active stack.
- R4: A candidate whose priority bits 7:4 are all ones never raises the request, even with the threshold at its largest value.
- R5: An acknowledge read while the request condition holds returns {19'b0, source core[2:0], id[9:0]}. It pushes the interrupt onto the active stack and forces the request line low in the following cycle.
- R6: An acknowledge read while the request condition does not hold returns 0x3FF and leaves running priority unchanged.
- R7: The highest-pending register (offset 0x18) returns the candidate in the acknowledge layout when it is valid, and 0x3FF when it is not. Reading it has no side effect.
- R8: Running priority (offset 0x14) reads 0xFF when no handler is active; otherwise it reads the innermost handler's priority bits 7:4 in bits 7:4, with bits 3:0 zero.
- R9: While a handler is active, a request also needs (candidate & G) < (running & G), where G keeps priority bits 7 down to bp+1. A binary point of 7 therefore blocks all pre-emption.
- R10: A binary-point write (offset 0x08, bits 2:0) below BP_MIN stores BP_MIN, and the stored value reads back.
- R11: An end-of-interrupt write (offset 0x10, id in bits 9:0) whose id equals the innermost handler's id retires that handler. A write with any other id is ignored.
- R12: With STACK_DEPTH handlers active (default 4), the request stays low and an acknowledge read returns 0x3FF.
- R13: Read data appears on bus_rdata one cycle after the read is presented and holds until the next read. The write-only end-of-interrupt offset and unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_valid | input | 1 | Distributor candidate present |
| pend_id | input | 10 | Candidate interrupt number |
| pend_cpu | input | 3 | Candidate originating-core number |
| pend_prio | input | 8 | Candidate priority, smaller is more urgent |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the word register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request to the core |

## Verification
A corrupted active stack shows up on the next running-priority read, which reports the wrong innermost level. It also shows within one cycle on the request line, because the pre-emption compare runs against that level. A lost push or a lost pop is exposed during unwinding: the end-of-interrupt sequence either reaches 0xFF too early or never reaches it. Threshold, enable or group-mask faults flip the request line one cycle after the stimulus. Acknowledge-side faults appear as a wrong identity in the very next read data.

// File: rtl/intc_cpu_pkg.sv
package intc_cpu_pkg;

    localparam int ID_W   = 10;
    localparam int CPU_W  = 3;
    localparam int PRIO_W = 8;
    localparam int LVL_W  = 4;
    localparam int BP_W   = 3;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;

    localparam logic [ID_W-1:0]   SPURIOUS_ID = 10'h3FF;
    localparam logic [DATA_W-1:0] IDLE_WORD   = 32'h0000_00FF;

    typedef struct packed {
        logic [CPU_W-1:0] cpu;
        logic [ID_W-1:0]  id;
    } irq_tag_t;

    typedef struct packed {
        logic [ID_W-1:0]  id;
        logic [LVL_W-1:0] lvl;
    } act_ent_t;

    typedef enum logic [2:0] {
        REG_CTRL  = 3'd0,
        REG_THR   = 3'd1,
        REG_BPT   = 3'd2,
        REG_ACK   = 3'd3,
        REG_EOI   = 3'd4,
        REG_RUN   = 3'd5,
        REG_HPEND = 3'd6,
        REG_NONE  = 3'd7
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(logic [ADDR_W-1:0] a);
        if (a[1:0] != 2'b00 || a[4:2] == 3'd7) return REG_NONE;
        return reg_sel_e'(a[4:2]);
    endfunction

    // keeps priority bits [7:bp+1]; bp = 7 yields an all-zero mask
    function automatic logic [PRIO_W-1:0] group_mask(logic [BP_W-1:0] bp);
        logic [BP_W:0] sh;
        sh = {1'b0, bp} + 1'b1;
        return {PRIO_W{1'b1}} << sh;
    endfunction

    function automatic logic [DATA_W-1:0] tag_word(irq_tag_t t);
        return {{(DATA_W-CPU_W-ID_W){1'b0}}, t};
    endfunction

endpackage

// File: rtl/intc_cpu_gate.sv
module intc_cpu_gate
    import intc_cpu_pkg::*;
(
    input  logic              enable,
    input  logic              pend_valid,
    input  logic [PRIO_W-1:0] pend_prio,
    input  logic [LVL_W-1:0]  thr,
    input  logic [BP_W-1:0]   bp,
    input  logic              active,
    input  logic [LVL_W-1:0]  run_lvl,
    input  logic              stack_full,
    output logic              req
);
    logic [PRIO_W-1:0] gmask;
    logic              pass_thr;
    logic              pass_pre;

    always_comb begin
        gmask    = group_mask(bp);
        pass_thr = pend_prio < {thr, {(PRIO_W-LVL_W){1'b0}}};
        pass_pre = !active ||
                   ((pend_prio & gmask) < ({run_lvl, {(PRIO_W-LVL_W){1'b0}}} & gmask));
        req      = enable && pend_valid && pass_thr && pass_pre && !stack_full;
    end

endmodule

// File: rtl/intc_cpu_stack.sv
module intc_cpu_stack
    import intc_cpu_pkg::*;
#(
    parameter int DEPTH = 4
)(
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  act_ent_t        push_ent,
    input  logic            eoi,
    input  logic [ID_W-1:0] eoi_id,
    output act_ent_t        top,
    output logic            active,
    output logic            full
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] cnt;
    act_ent_t         slot [DEPTH];
    logic             pop;

    assign active = (cnt != '0);
    assign full   = (cnt == CNT_W'(DEPTH));
    assign pop    = eoi && active && (top.id == eoi_id);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (push) begin
            cnt <= cnt + 1'b1;
        end else if (pop) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) begin
                slot[i] <= '0;
            end else if (push && cnt == CNT_W'(i)) begin
                slot[i] <= push_ent;
            end
        end
    end

    always_comb begin
        top = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cnt == CNT_W'(i + 1)) top = slot[i];
        end
    end

    a_r12_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    a_r5_push_grows: assert property (@(posedge clk) disable iff (rst)
        push |=> cnt == $past(cnt) + 1'b1);
    a_r11_hold_without_match: assert property (@(posedge clk) disable iff (rst)
        (!push && !pop) |=> $stable(cnt));

endmodule

// File: rtl/intc_cpu_regs.sv
module intc_cpu_regs
    import intc_cpu_pkg::*;
#(
    parameter int BP_MIN = 3
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              req,
    input  logic              pend_valid,
    input  irq_tag_t          pend_tag,
    input  logic              active,
    input  logic [LVL_W-1:0]  run_lvl,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              enable,
    output logic [LVL_W-1:0]  thr,
    output logic [BP_W-1:0]   bp,
    output logic              push,
    output logic              eoi,
    output logic [ID_W-1:0]   eoi_id
);
    localparam logic [BP_W-1:0] BP_FLOOR = BP_W'(BP_MIN);

    reg_sel_e          rsel;
    logic              rd_en;
    logic              wr_en;
    logic [DATA_W-1:0] rd_val;
    logic [BP_W-1:0]   bp_in;
    logic              unused_wbits;

    assign rsel   = decode_addr(bus_addr);
    assign rd_en  = bus_sel && !bus_wr;
    assign wr_en  = bus_sel && bus_wr;
    assign push   = rd_en && (rsel == REG_ACK) && req;
    assign eoi    = wr_en && (rsel == REG_EOI);
    assign eoi_id = bus_wdata[ID_W-1:0];
    assign bp_in  = bus_wdata[BP_W-1:0];
    assign unused_wbits = ^{bus_wdata[DATA_W-1:PRIO_W], bus_wdata[LVL_W-1:BP_W],
                            bus_wdata[ID_W+CPU_W-1:ID_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= 1'b0;
            thr    <= '0;
            bp     <= BP_FLOOR;
        end else if (wr_en) begin
            case (rsel)
                REG_CTRL: enable <= bus_wdata[0];
                REG_THR:  thr    <= bus_wdata[PRIO_W-1:PRIO_W-LVL_W];
                REG_BPT:  bp     <= (bp_in < BP_FLOOR) ? BP_FLOOR : bp_in;
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (rsel)
            REG_CTRL:  rd_val = {{(DATA_W-1){1'b0}}, enable};
            REG_THR:   rd_val = {{(DATA_W-PRIO_W){1'b0}}, thr, {(PRIO_W-LVL_W){1'b0}}};
            REG_BPT:   rd_val = {{(DATA_W-BP_W){1'b0}}, bp};
            REG_ACK:   rd_val = req ? tag_word(pend_tag)
                                    : {{(DATA_W-ID_W){1'b0}}, SPURIOUS_ID};
            REG_RUN:   rd_val = active ? {{(DATA_W-PRIO_W){1'b0}}, run_lvl, {(PRIO_W-LVL_W){1'b0}}}
                                       : IDLE_WORD;
            REG_HPEND: rd_val = pend_valid ? tag_word(pend_tag)
                                           : {{(DATA_W-ID_W){1'b0}}, SPURIOUS_ID};
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (rd_en) begin
            bus_rdata <= rd_val;
        end
    end

    a_r10_bp_floor: assert property (@(posedge clk) disable iff (rst)
        bp >= BP_FLOOR);
    a_r8_idle_running: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rsel == REG_RUN && !active) |=> bus_rdata == IDLE_WORD);
    a_r3_disabled_ack: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rsel == REG_ACK && !enable) |=> bus_rdata == DATA_W'(SPURIOUS_ID));
    a_r13_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(bus_rdata));

endmodule

// File: rtl/intc_cpu_if.sv
module intc_cpu_if
    import intc_cpu_pkg::*;
#(
    parameter int STACK_DEPTH = 4,
    parameter int BP_MIN      = 3
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              pend_valid,
    input  logic [ID_W-1:0]   pend_id,
    input  logic [CPU_W-1:0]  pend_cpu,
    input  logic [PRIO_W-1:0] pend_prio,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    irq_tag_t         pend_tag;
    act_ent_t         push_ent;
    act_ent_t         top;
    logic             enable;
    logic [LVL_W-1:0] thr;
    logic [BP_W-1:0]  bp;
    logic             active;
    logic             full;
    logic             req;
    logic             push;
    logic             eoi;
    logic [ID_W-1:0]  eoi_id;

    assign pend_tag.cpu = pend_cpu;
    assign pend_tag.id  = pend_id;
    assign push_ent.id  = pend_id;
    assign push_ent.lvl = pend_prio[PRIO_W-1:PRIO_W-LVL_W];

    intc_cpu_regs #(.BP_MIN(BP_MIN)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .req        (req),
        .pend_valid (pend_valid),
        .pend_tag   (pend_tag),
        .active     (active),
        .run_lvl    (top.lvl),
        .bus_rdata  (bus_rdata),
        .enable     (enable),
        .thr        (thr),
        .bp         (bp),
        .push       (push),
        .eoi        (eoi),
        .eoi_id     (eoi_id)
    );

    intc_cpu_gate u_gate (
        .enable     (enable),
        .pend_valid (pend_valid),
        .pend_prio  (pend_prio),
        .thr        (thr),
        .bp         (bp),
        .active     (active),
        .run_lvl    (top.lvl),
        .stack_full (full),
        .req        (req)
    );

    intc_cpu_stack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_ent (push_ent),
        .eoi      (eoi),
        .eoi_id   (eoi_id),
        .top      (top),
        .active   (active),
        .full     (full)
    );

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= req && !push;
    end

    a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !irq);
    a_r4_lowest_never: assert property (@(posedge clk) disable iff (rst)
        (pend_prio[PRIO_W-1:PRIO_W-LVL_W] == {LVL_W{1'b1}}) |=> !irq);
    a_r5_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
        push |=> !irq);
    a_r12_full_quiet: assert property (@(posedge clk) disable iff (rst)
        full |=> !irq);

endmodule

// File: tb/intc_cpu_if_tb.sv
module intc_cpu_if_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pend_valid = 1'b0;
    logic [9:0]  pend_id = '0;
    logic [2:0]  pend_cpu = '0;
    logic [7:0]  pend_prio = 8'hFF;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    localparam logic [4:0] A_CTRL = 5'h00, A_THR = 5'h04, A_BPT = 5'h08, A_ACK = 5'h0C,
                           A_EOI = 5'h10, A_RUN = 5'h14, A_HP = 5'h18, A_BAD = 5'h1C;

    always #5 clk = ~clk;

    intc_cpu_if u_dut (
        .clk(clk), .rst(rst), .pend_valid(pend_valid), .pend_id(pend_id),
        .pend_cpu(pend_cpu), .pend_prio(pend_prio), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops the expected read word after the capturing edge
    always @(posedge clk) begin
        if (bus_sel && !bus_wr) begin
            #1;
            if (exp_q.size() != 0) check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic rd(logic [4:0] a, logic [31:0] exp, string req);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic chk_irq(logic exp, string req);
        @(negedge clk);
        check(req, {31'b0, irq}, {31'b0, exp});
    endtask

    task automatic set_pend(logic v, logic [9:0] id, logic [2:0] cpu, logic [7:0] p);
        pend_valid = v; pend_id = id; pend_cpu = cpu; pend_prio = p;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk_irq(1'b0, "R1");
        rd(A_CTRL, 32'h0, "R1");
        rd(A_THR, 32'h0, "R1");
        rd(A_BPT, 32'h3, "R1");
        rd(A_RUN, 32'hFF, "R1");
        rd(A_HP, 32'h3FF, "R7");
        rd(A_ACK, 32'h3FF, "R6");
        // R3 disabled
        set_pend(1'b1, 10'h025, 3'd2, 8'h40);
        wr(A_THR, 32'hFF);
        rd(A_THR, 32'hF0, "R2");
        chk_irq(1'b0, "R3");
        rd(A_ACK, 32'h3FF, "R3");
        rd(A_RUN, 32'hFF, "R3");
        // R2 enable
        wr(A_CTRL, 32'h1);
        chk_irq(1'b1, "R2");
        rd(A_HP, 32'h825, "R7");
        chk_irq(1'b1, "R7");
        wr(A_THR, 32'h40);
        chk_irq(1'b0, "R2");
        // R6 ack without request
        rd(A_ACK, 32'h3FF, "R6");
        rd(A_RUN, 32'hFF, "R6");
        wr(A_THR, 32'h50);
        chk_irq(1'b1, "R2");
        // R4 lowest level
        wr(A_THR, 32'hF0);
        set_pend(1'b1, 10'h025, 3'd2, 8'hF3);
        chk_irq(1'b0, "R4");
        chk_irq(1'b0, "R4");
        set_pend(1'b1, 10'h025, 3'd2, 8'h40);
        wr(A_THR, 32'h50);
        chk_irq(1'b1, "R2");
        // R5 acknowledge
        rd(A_ACK, 32'h825, "R5");
        check("R5", {31'b0, irq}, 32'h0);
        chk_irq(1'b0, "R5");
        rd(A_RUN, 32'h40, "R8");
        // R9 pre-emption
        set_pend(1'b1, 10'h031, 3'd1, 8'h30);
        chk_irq(1'b1, "R9");
        set_pend(1'b1, 10'h031, 3'd1, 8'h48);
        chk_irq(1'b0, "R9");
        wr(A_BPT, 32'h7);
        set_pend(1'b1, 10'h031, 3'd1, 8'h30);
        chk_irq(1'b0, "R9");
        wr(A_BPT, 32'h1);
        rd(A_BPT, 32'h3, "R10");
        wr(A_BPT, 32'h5);
        rd(A_BPT, 32'h5, "R10");
        chk_irq(1'b1, "R9");
        set_pend(1'b1, 10'h031, 3'd1, 8'h48);
        chk_irq(1'b0, "R9");
        wr(A_BPT, 32'h3);
        // nesting to full
        set_pend(1'b1, 10'h031, 3'd1, 8'h30);
        rd(A_ACK, 32'h431, "R5");
        rd(A_RUN, 32'h30, "R8");
        set_pend(1'b1, 10'h012, 3'd0, 8'h20);
        rd(A_ACK, 32'h012, "R5");
        set_pend(1'b1, 10'h007, 3'd0, 8'h10);
        rd(A_ACK, 32'h007, "R5");
        rd(A_RUN, 32'h10, "R8");
        set_pend(1'b1, 10'h003, 3'd0, 8'h00);
        chk_irq(1'b0, "R12");
        rd(A_ACK, 32'h3FF, "R12");
        rd(A_RUN, 32'h10, "R12");
        // R13 write-only and unmapped reads
        rd(A_EOI, 32'h0, "R13");
        rd(A_BAD, 32'h0, "R13");
        // R11 unwinding
        set_pend(1'b0, 10'h000, 3'd0, 8'hFF);
        wr(A_EOI, 32'h012);
        rd(A_RUN, 32'h10, "R11");
        wr(A_EOI, 32'h007);
        rd(A_RUN, 32'h20, "R11");
        wr(A_EOI, 32'h012);
        rd(A_RUN, 32'h30, "R11");
        wr(A_EOI, 32'h031);
        rd(A_RUN, 32'h40, "R11");
        wr(A_EOI, 32'h025);
        rd(A_RUN, 32'hFF, "R8");
        rd(A_HP, 32'h3FF, "R7");
        chk_irq(1'b0, "R2");
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule